// File: doc/BRIEF.md
# GPIO Controller with Edge-Triggered Interrupts

This block is a 32-line general-purpose I/O peripheral on a plain 32-bit register bus. Software sets each line as an input or an output. An output line can be push-pull or open-drain. Software writes an output latch and reads back a data word that mixes the latched values of output lines with the sampled values of input lines. An input line feeds the data word only when its input buffer enable is set.

Every pin passes through a two-flop synchronizer. An edge detector compares each synchronized value with its value one cycle earlier. When the selected edge appears, the line's sticky event bit is set. A per-line sense bit selects falling edges only or both edges. Software clears event bits by writing ones to them. A per-line mask gates the event bits onto a single interrupt output that is high whenever any unmasked event is pending.

Line numbers run opposite to bit numbers. Line n sits at bit (31 - n) of every per-line register, while the pin vectors `pin_in`, `pin_out` and `pin_oe` are indexed by line number. Bus writes take effect at the clock edge. Reads are combinational from the current register state.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset, every register reads 0 (all lines are inputs), no `pin_oe` bit is set and `irq_out` is 0.
- R2: Line n corresponds to bit (31 - n) of every per-line register. Pin vectors are indexed by line, so line 0 is bit 31 and pin index 0.
- R3: The direction register is at offset 0x00, and a 1 makes the line an output. An input line never drives its pad. A push-pull output drives its latch bit on `pin_out` with `pin_oe` set.
- R4: The open-drain register is at offset 0x04. An output line with its open-drain bit at 1 drives low when its latch bit is 0 and releases the pad (`pin_oe` 0) when its latch bit is 1. An open-drain line never drives high.
- R5: The data register is at offset 0x08. A write loads the output latch. A read returns the latch bit for output lines. For input lines it returns the synchronized pin value when the input buffer enable bit (offset 0x18) is 1, and 0 otherwise. A pin change shows up in a read after the second rising clock edge.
- R6: The event register is at offset 0x0C. A selected edge on a synchronized pin sets the line's event bit at the third rising clock edge after the pin change. Detection does not depend on direction or input buffer enable.
- R7: The sense register is at offset 0x14. A sense bit of 1 sets the event on falling edges only. A sense bit of 0 sets it on both rising and falling edges.
- R8: Writing 1 to an event bit clears it. Writing 0 leaves it unchanged, and a write never sets an event bit.
- R9: If a new edge and a write-one-to-clear of the same event bit meet at one clock edge, the event bit stays set.
- R10: The mask register is at offset 0x10. `irq_out` is 1 exactly while some bit of (event AND mask) is 1.
- R11: Any address that is not word-aligned, and word offset 0x1C, reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Byte address of the register |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | 32 | Pad input values, index = line number |
| pin_out | output | 32 | Pad output values, index = line number |
| pin_oe | output | 32 | Pad output enables, index = line number |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The bench targets the bit reversal on both the registers and the pins, so a design that indexes pins by bit position drives or reads the wrong pad. It measures the exact edge at which a pin change reaches the data read and the event bit, which exposes a synchronizer that is one stage too short or too long. It times a clear write to land on the same edge as a new falling edge, so a design where clear wins loses that event. It also checks that falling-only sense ignores rising edges, that writing zeros or unset bits never sets or clears events, and that open-drain lines release instead of driving high.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

    localparam int unsigned REG_AW = 5;

    localparam logic [REG_AW-1:0] OFS_DIR = 5'h00;
    localparam logic [REG_AW-1:0] OFS_ODR = 5'h04;
    localparam logic [REG_AW-1:0] OFS_DAT = 5'h08;
    localparam logic [REG_AW-1:0] OFS_EVT = 5'h0C;
    localparam logic [REG_AW-1:0] OFS_MSK = 5'h10;
    localparam logic [REG_AW-1:0] OFS_SNS = 5'h14;
    localparam logic [REG_AW-1:0] OFS_IBE = 5'h18;

    typedef enum logic [2:0] {
        RS_DIR  = 3'd0,
        RS_ODR  = 3'd1,
        RS_DAT  = 3'd2,
        RS_EVT  = 3'd3,
        RS_MSK  = 3'd4,
        RS_SNS  = 3'd5,
        RS_IBE  = 3'd6,
        RS_NONE = 3'd7
    } reg_sel_e;

    // Word index selects the register; misaligned addresses select nothing.
    function automatic reg_sel_e decode_addr(input logic [REG_AW-1:0] a);
        reg_sel_e s;
        if (a[1:0] != 2'b00) begin
            s = RS_NONE;
        end else begin
            case (a[REG_AW-1:2])
                3'd0:    s = RS_DIR;
                3'd1:    s = RS_ODR;
                3'd2:    s = RS_DAT;
                3'd3:    s = RS_EVT;
                3'd4:    s = RS_MSK;
                3'd5:    s = RS_SNS;
                3'd6:    s = RS_IBE;
                default: s = RS_NONE;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] stab_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            stab_q <= '0;
        end else begin
            meta_q <= d;
            stab_q <= meta_q;
        end
    end

    assign q = stab_q;

endmodule

// File: rtl/gpio_edge_unit.sv
module gpio_edge_unit #(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] cur,
    input  logic [WIDTH-1:0] prev,
    input  logic [WIDTH-1:0] fall_only,
    input  logic [WIDTH-1:0] evt_q,
    input  logic [WIDTH-1:0] clr,
    output logic [WIDTH-1:0] evt_d
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic rise_w;
        logic fall_w;
        logic hit_w;

        assign rise_w   = cur[b] & ~prev[b];
        assign fall_w   = ~cur[b] & prev[b];
        assign hit_w    = fall_only[b] ? fall_w : (rise_w | fall_w);
        // A fresh edge overrides a clear landing on the same edge.
        assign evt_d[b] = (evt_q[b] & ~clr[b]) | hit_w;
    end

endmodule

// File: rtl/gpio_pad_drv.sv
module gpio_pad_drv #(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] dir_b,
    input  logic [WIDTH-1:0] odr_b,
    input  logic [WIDTH-1:0] dout_b,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_oe
);

    // Register bits are reversed relative to line (pad) numbers.
    for (genvar i = 0; i < WIDTH; i++) begin : g_line
        localparam int unsigned B = WIDTH - 1 - i;
        assign pad_oe[i]  = dir_b[B] & (~odr_b[B] | ~dout_b[B]);
        assign pad_out[i] = dout_b[B] & ~odr_b[B];
    end

endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
    import gpio_edge_pkg::*;
#(
    parameter int unsigned NUM_LINES = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [REG_AW-1:0]    bus_addr,
    input  logic                 bus_wr,
    input  logic [NUM_LINES-1:0] bus_wdata,
    output logic [NUM_LINES-1:0] bus_rdata,
    input  logic [NUM_LINES-1:0] pin_in,
    output logic [NUM_LINES-1:0] pin_out,
    output logic [NUM_LINES-1:0] pin_oe,
    output logic                 irq_out
);

    localparam int unsigned N = NUM_LINES;

    typedef struct packed {
        logic [N-1:0] dir;
        logic [N-1:0] odr;
        logic [N-1:0] dout;
        logic [N-1:0] evt;
        logic [N-1:0] mask;
        logic [N-1:0] sense;
        logic [N-1:0] ibe;
        logic [N-1:0] prev;
    } state_t;

    state_t st_d, st_q;

    logic [N-1:0] sync_line;
    logic [N-1:0] in_b;
    logic [N-1:0] clr_b;
    logic [N-1:0] evt_nx;
    logic [N-1:0] dat_rd;
    reg_sel_e     sel;

    gpio_sync2 #(.WIDTH(N)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (sync_line)
    );

    for (genvar i = 0; i < N; i++) begin : g_rev
        assign in_b[N-1-i] = sync_line[i];
    end

    assign sel   = decode_addr(bus_addr);
    assign clr_b = (bus_wr && sel == RS_EVT) ? bus_wdata : '0;

    gpio_edge_unit #(.WIDTH(N)) u_edge (
        .cur       (in_b),
        .prev      (st_q.prev),
        .fall_only (st_q.sense),
        .evt_q     (st_q.evt),
        .clr       (clr_b),
        .evt_d     (evt_nx)
    );

    always_comb begin
        st_d      = st_q;
        st_d.prev = in_b;
        st_d.evt  = evt_nx;
        if (bus_wr) begin
            case (sel)
                RS_DIR:  st_d.dir   = bus_wdata;
                RS_ODR:  st_d.odr   = bus_wdata;
                RS_DAT:  st_d.dout  = bus_wdata;
                RS_MSK:  st_d.mask  = bus_wdata;
                RS_SNS:  st_d.sense = bus_wdata;
                RS_IBE:  st_d.ibe   = bus_wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dat_rd = (st_q.dout & st_q.dir) | (in_b & st_q.ibe & ~st_q.dir);

    always_comb begin
        case (sel)
            RS_DIR:  bus_rdata = st_q.dir;
            RS_ODR:  bus_rdata = st_q.odr;
            RS_DAT:  bus_rdata = dat_rd;
            RS_EVT:  bus_rdata = st_q.evt;
            RS_MSK:  bus_rdata = st_q.mask;
            RS_SNS:  bus_rdata = st_q.sense;
            RS_IBE:  bus_rdata = st_q.ibe;
            default: bus_rdata = '0;
        endcase
    end

    gpio_pad_drv #(.WIDTH(N)) u_pad (
        .dir_b   (st_q.dir),
        .odr_b   (st_q.odr),
        .dout_b  (st_q.dout),
        .pad_out (pin_out),
        .pad_oe  (pin_oe)
    );

    assign irq_out = |(st_q.evt & st_q.mask);

endmodule

// File: rtl/gpio_edge_ctrl_chk.sv
module gpio_edge_ctrl_chk
    import gpio_edge_pkg::*;
#(
    parameter int unsigned NUM_LINES = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [REG_AW-1:0]    bus_addr,
    input logic                 bus_wr,
    input logic [NUM_LINES-1:0] bus_wdata,
    input logic [NUM_LINES-1:0] pin_out,
    input logic [NUM_LINES-1:0] pin_oe,
    input logic                 irq_out,
    input logic [NUM_LINES-1:0] dir_q,
    input logic [NUM_LINES-1:0] odr_q,
    input logic [NUM_LINES-1:0] evt_q,
    input logic [NUM_LINES-1:0] mask_q,
    input logic [NUM_LINES-1:0] sense_q,
    input logic [NUM_LINES-1:0] prev_q
);

    localparam int unsigned N = NUM_LINES;

    logic [N-1:0] dir_ln;
    logic [N-1:0] odr_ln;
    logic [N-1:0] clr_w;

    for (genvar i = 0; i < N; i++) begin : g_rev
        assign dir_ln[i] = dir_q[N-1-i];
        assign odr_ln[i] = odr_q[N-1-i];
    end

    assign clr_w = (bus_wr && bus_addr == OFS_EVT) ? bus_wdata : '0;

    // R3: a line configured as input never enables its pad driver
    a_r3_input_undriven: assert property (@(posedge clk) disable iff (!rst_n)
        ((~dir_ln & pin_oe) == '0));

    // R4: an open-drain line never drives a high level
    a_r4_od_never_high: assert property (@(posedge clk) disable iff (!rst_n)
        ((odr_ln & pin_oe & pin_out) == '0));

    // R8: an event bit not written with 1 stays set
    a_r8_evt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((evt_q & $past(evt_q & ~clr_w)) == $past(evt_q & ~clr_w)));

    // R6: an event bit only rises when the synchronized line changed
    a_r6_evt_needs_change: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((evt_q & ~$past(evt_q) & ~($past(prev_q) ^ prev_q)) == '0));

    // R7: with falling-only sense a new event implies the line is now low
    a_r7_fall_only: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((evt_q & ~$past(evt_q) & $past(sense_q) & prev_q) == '0));

    // R10: no interrupt while every mask bit is clear
    a_r10_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq_out);

endmodule

bind gpio_edge_ctrl gpio_edge_ctrl_chk #(.NUM_LINES(NUM_LINES)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .irq_out   (irq_out),
    .dir_q     (st_q.dir),
    .odr_q     (st_q.odr),
    .evt_q     (st_q.evt),
    .mask_q    (st_q.mask),
    .sense_q   (st_q.sense),
    .prev_q    (st_q.prev)
);

// File: tb/gpio_edge_ctrl_tb_top.sv
`timescale 1ns/1ps
module gpio_edge_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out;
    logic [31:0] pin_oe;
    logic        irq_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    gpio_edge_ctrl dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .irq_out   (irq_out)
    );

    typedef struct packed {
        logic [4:0]  addr;
        logic [31:0] wdata;
        logic [31:0] exp;
    } vec_t;

    // write-then-read vectors; pins held at 0 throughout
    localparam vec_t VECS [8] = '{
        '{5'h00, 32'h0000_FFFF, 32'h0000_FFFF},   // R3 direction
        '{5'h04, 32'h1234_5678, 32'h1234_5678},   // R4 open-drain
        '{5'h10, 32'h0F0F_0000, 32'h0F0F_0000},   // R10 mask
        '{5'h14, 32'hFFFF_0000, 32'hFFFF_0000},   // R7 sense
        '{5'h18, 32'h00FF_00FF, 32'h00FF_00FF},   // R5 input enable
        '{5'h0C, 32'hFFFF_FFFF, 32'h0000_0000},   // R8 write never sets
        '{5'h1C, 32'hDEAD_BEEF, 32'h0000_0000},   // R11 unmapped
        '{5'h08, 32'h0F00_00F0, 32'h0000_00F0}    // R5 outputs show latch
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_n(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin
        logic [31:0] v;
        wait_n(4);
        rst_n = 1'b1;

        // R1: reset state
        for (int k = 0; k < 7; k++) begin
            rd(5'(k * 4), v);
            check("R1 reg after reset", v, 32'h0);
        end
        check("R1 pin_oe after reset", pin_oe, 32'h0);
        check("R1 irq after reset", {31'h0, irq_out}, 32'h0);

        // vector table
        for (int k = 0; k < 8; k++) begin
            wr(VECS[k].addr, VECS[k].wdata);
            rd(VECS[k].addr, v);
            check("R3/R4/R5/R7/R8/R10/R11 table", v, VECS[k].exp);
        end
        wr(5'h00, 0); wr(5'h04, 0); wr(5'h10, 0);
        wr(5'h14, 0); wr(5'h18, 0); wr(5'h08, 0);

        // R2 / R3: line 0 is bit 31
        wr(5'h00, 32'h8000_0000);
        wr(5'h08, 32'h8000_0001);
        #1 check("R2 line0 drives pin index 0", pin_oe, 32'h0000_0001);
        check("R3 push-pull drives latch", pin_out & 32'h1, 32'h1);
        rd(5'h08, v);
        check("R5 output reads latch, input disabled reads 0", v, 32'h8000_0000);

        // R4: open-drain
        wr(5'h04, 32'h8000_0000);
        #1 check("R4 od latch 1 releases", pin_oe, 32'h0);
        wr(5'h08, 32'h0);
        #1 check("R4 od latch 0 drives", pin_oe, 32'h1);
        check("R4 od drives low", pin_out & 32'h1, 32'h0);
        wr(5'h04, 0); wr(5'h00, 0);

        // R5: input enable and latency (line 5 = bit 26)
        @(negedge clk); pin_in[5] = 1'b1;
        wait_n(3);
        rd(5'h08, v);
        check("R5 input with enable 0 reads 0", v, 32'h0);
        wr(5'h18, 32'h0400_0000);
        rd(5'h08, v);
        check("R5 input with enable 1 reads pin", v, 32'h0400_0000);
        @(negedge clk); pin_in[5] = 1'b0; bus_addr = 5'h08;
        @(negedge clk); #1 check("R5 after one edge still old", bus_rdata, 32'h0400_0000);
        @(negedge clk); #1 check("R5 after two edges new", bus_rdata, 32'h0);
        wr(5'h0C, 32'hFFFF_FFFF);
        wr(5'h18, 0);

        // R6: any-edge on line 3 (bit 28), exact latency
        @(negedge clk); pin_in[3] = 1'b1; bus_addr = 5'h0C;
        @(negedge clk);
        @(negedge clk); #1 check("R6 not yet set after two edges", bus_rdata, 32'h0);
        @(negedge clk); #1 check("R6 rise sets after third edge", bus_rdata, 32'h1000_0000);
        wr(5'h0C, 32'h1000_0000);
        rd(5'h0C, v);
        check("R8 write one clears", v, 32'h0);
        @(negedge clk); pin_in[3] = 1'b0;
        wait_n(4);
        rd(5'h0C, v);
        check("R6 fall sets in any-edge mode", v, 32'h1000_0000);
        wr(5'h0C, 32'h1000_0000);

        // R7: falling only
        wr(5'h14, 32'h1000_0000);
        @(negedge clk); pin_in[3] = 1'b1;
        wait_n(4);
        rd(5'h0C, v);
        check("R7 rise ignored in falling mode", v, 32'h0);
        @(negedge clk); pin_in[3] = 1'b0;
        wait_n(4);
        rd(5'h0C, v);
        check("R7 fall sets in falling mode", v, 32'h1000_0000);

        // R8: zeros and unset bits
        wr(5'h0C, 32'h0);
        rd(5'h0C, v);
        check("R8 write zero keeps event", v, 32'h1000_0000);
        wr(5'h0C, 32'h0000_0001);
        rd(5'h0C, v);
        check("R8 other bit write no effect", v, 32'h1000_0000);

        // R10: interrupt masking
        #1 check("R10 irq low with mask 0", {31'h0, irq_out}, 32'h0);
        wr(5'h10, 32'h0000_0001);
        #1 check("R10 irq low with other mask", {31'h0, irq_out}, 32'h0);
        wr(5'h10, 32'h1000_0000);
        #1 check("R10 irq high with matching mask", {31'h0, irq_out}, 32'h1);
        wr(5'h0C, 32'h1000_0000);
        #1 check("R10 irq low after clear", {31'h0, irq_out}, 32'h0);

        // R9: new edge and clear on the same clock edge
        @(negedge clk); pin_in[3] = 1'b1;
        wait_n(4);
        @(negedge clk); pin_in[3] = 1'b0;
        @(negedge clk);
        @(negedge clk); bus_addr = 5'h0C; bus_wdata = 32'h1000_0000; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
        #1 check("R9 set wins over clear", bus_rdata, 32'h1000_0000);
        check("R10 irq follows event", {31'h0, irq_out}, 32'h1);
        wr(5'h0C, 32'hFFFF_FFFF);

        // R11: misaligned and unmapped
        wr(5'h01, 32'hFFFF_FFFF);
        rd(5'h00, v);
        check("R11 misaligned write ignored", v, 32'h0);
        check("R11 pads idle after misaligned write", pin_oe, 32'h0);
        rd(5'h02, v);
        check("R11 misaligned read zero", v, 32'h0);
        rd(5'h1C, v);
        check("R11 unmapped read zero", v, 32'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog act=timeout exp=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule